// File: doc/BRIEF.md
# One-Hot Response CRC Signature Compactor

This block sits at the output of a neural-network classifier under built-in test. For every test the classifier produces a predicted label as a K-bit one-hot vector. The block compresses the whole stream of these vectors into a set of signatures. Each output line has its own serial CRC-16 register, and that register takes in one bit of its line for every accepted response. When the test sequence ends, a finish strobe compares all signatures with fault-free golden values that are supplied from outside. The block then reports done and pass.

Responses arrive on a valid/ready stream. The block is always ready, except in a cycle in which `clear` is high. In that cycle `resp_ready` is low, so a valid response is not accepted and the source must hold it. The block also checks every accepted response for the one-hot property. A vector with no bit set, or with more than one bit set, latches a sticky protocol-error flag, and that flag forces a fail at the next compare.

Top module: `onehot_crc_compactor`

## Requirements
- R1: After reset, `done`, `pass` and `proto_err` are 0, `resp_ready` is 1, and every lane signature holds 0xFFFF.
- R2: An accepted response advances lane i by one serial CRC step, with `resp_data[i]` as the input bit. The step is feedback = sig[15] XOR bit, then sig = (sig << 1) XOR (feedback ? 0x1021 : 0).
- R3: A lane signature changes only in a cycle where `resp_valid` and `resp_ready` are both high. Idle cycles and finish strobes leave it unchanged.
- R4: `resp_ready` is 0 in every cycle in which `clear` is 1, and a response offered in that cycle is not absorbed.
- R5: A cycle with `clear` high sets every signature to 0xFFFF and clears `proto_err`, `done` and `pass` at the next edge.
- R6: An accepted response with zero bits set, or with two or more bits set, sets `proto_err` at the next edge. The flag stays set until `clear`.
- R7: One cycle after `finish` is high, `done` is 1. `pass` is 1 only if every lane matches its golden value and `proto_err` was 0. Both outputs hold until the next finish or clear.
- R8: The golden value for lane i is `golden_sig[16*i+15 : 16*i]`. A mismatch on any single lane makes `pass` 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| clear | input | 1 | Restart: reinitialise signatures and flags |
| resp_valid | input | 1 | Response on `resp_data` is valid |
| resp_ready | output | 1 | Block can accept a response this cycle |
| resp_data | input | K | One-hot predicted label |
| golden_sig | input | 16*K | Fault-free signatures, lane i in bits 16*i+15:16*i |
| finish | input | 1 | End of test sequence: compare strobe |
| done | output | 1 | A compare result is held |
| pass | output | 1 | All lanes matched and no protocol error |
| proto_err | output | 1 | Sticky: a non-one-hot response was accepted |

## Verification
The signatures are not visible at the ports. Their values, and the claim that idle cycles or a clear-cycle offer leave them alone, can only be observed through the pass result of a compare. The bench therefore keeps its own per-lane CRC model. At each finish it presents either that model's exact golden values or a copy with one bit flipped in one lane. Stretches of idle cycles, responses offered during clear, and occasional zero or multi-hot vectors are mixed into long random one-hot streams, so that a stray signature update or a missed one shows up as a wrong pass bit.

// File: rtl/ocs_pkg.sv
package ocs_pkg;
  localparam int SIG_W = 16;
  localparam logic [SIG_W-1:0] SIG_POLY = 16'h1021;
  localparam logic [SIG_W-1:0] SIG_SEED = 16'hFFFF;

  // one serial CRC step, MSB-first shift
  function automatic logic [SIG_W-1:0] crc_step(input logic [SIG_W-1:0] s, input logic b);
    logic fb;
    fb = s[SIG_W-1] ^ b;
    crc_step = {s[SIG_W-2:0], 1'b0} ^ (fb ? SIG_POLY : '0);
  endfunction
endpackage

// File: rtl/ocs_sig_lane.sv
module ocs_sig_lane
  import ocs_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             init,
  input  logic             step,
  input  logic             bit_in,
  output logic [SIG_W-1:0] sig
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    sig <= SIG_SEED;
    else if (init) sig <= SIG_SEED;
    else if (step) sig <= crc_step(sig, bit_in);
  end
endmodule

// File: rtl/ocs_onehot_chk.sv
module ocs_onehot_chk #(
  parameter int K = 10
) (
  input  logic [K-1:0] vec,
  output logic         is_onehot
);
  // running "seen one" and "seen more" flags across the vector
  logic [K:0] seen_one;
  logic [K:0] seen_many;
  assign seen_one[0]  = 1'b0;
  assign seen_many[0] = 1'b0;
  for (genvar i = 0; i < K; i++) begin : g_scan
    assign seen_one[i+1]  = seen_one[i] | vec[i];
    assign seen_many[i+1] = seen_many[i] | (seen_one[i] & vec[i]);
  end
  assign is_onehot = seen_one[K] & ~seen_many[K];
endmodule

// File: rtl/ocs_sig_match.sv
module ocs_sig_match
  import ocs_pkg::*;
#(
  parameter int K = 10
) (
  input  logic [K*SIG_W-1:0] sig_flat,
  input  logic [K*SIG_W-1:0] golden_flat,
  output logic               all_match
);
  logic [K-1:0] lane_eq;
  for (genvar i = 0; i < K; i++) begin : g_cmp
    assign lane_eq[i] = (sig_flat[i*SIG_W +: SIG_W] == golden_flat[i*SIG_W +: SIG_W]);
  end
  assign all_match = &lane_eq;
endmodule

// File: rtl/onehot_crc_compactor.sv
module onehot_crc_compactor
  import ocs_pkg::*;
#(
  parameter int K = 10
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               clear,
  input  logic               resp_valid,
  output logic               resp_ready,
  input  logic [K-1:0]       resp_data,
  input  logic [K*SIG_W-1:0] golden_sig,
  input  logic               finish,
  output logic               done,
  output logic               pass,
  output logic               proto_err
);
  localparam int FLAT_W = K * SIG_W;

  logic              accept;
  logic              is_onehot;
  logic              all_match;
  logic [FLAT_W-1:0] sig_flat;
  logic              err_q, done_q, pass_q;

  assign resp_ready = ~clear;
  assign accept     = resp_valid & resp_ready;

  for (genvar i = 0; i < K; i++) begin : g_lane
    ocs_sig_lane u_lane (
      .clk    (clk),
      .rst_n  (rst_n),
      .init   (clear),
      .step   (accept),
      .bit_in (resp_data[i]),
      .sig    (sig_flat[i*SIG_W +: SIG_W])
    );
  end

  ocs_onehot_chk #(.K(K)) u_onehot (
    .vec       (resp_data),
    .is_onehot (is_onehot)
  );

  ocs_sig_match #(.K(K)) u_match (
    .sig_flat    (sig_flat),
    .golden_flat (golden_sig),
    .all_match   (all_match)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      err_q  <= 1'b0;
      done_q <= 1'b0;
      pass_q <= 1'b0;
    end else if (clear) begin
      err_q  <= 1'b0;
      done_q <= 1'b0;
      pass_q <= 1'b0;
    end else begin
      if (accept && !is_onehot) err_q <= 1'b1;
      if (finish) begin
        done_q <= 1'b1;
        pass_q <= all_match & ~err_q;
      end
    end
  end

  assign done      = done_q;
  assign pass      = pass_q;
  assign proto_err = err_q;
endmodule

// File: rtl/onehot_crc_compactor_chk.sv
module onehot_crc_compactor_chk
  import ocs_pkg::*;
#(
  parameter int K = 10
) (
  input logic               clk,
  input logic               rst_n,
  input logic               clear,
  input logic               resp_valid,
  input logic               resp_ready,
  input logic [K-1:0]       resp_data,
  input logic               finish,
  input logic               done,
  input logic               pass,
  input logic               proto_err,
  input logic [K*SIG_W-1:0] sig_flat
);
  assert_hold_idle_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!clear && !(resp_valid && resp_ready)) |=> $stable(sig_flat));

  assert_ready_low_R4: assert property (@(posedge clk) disable iff (!rst_n)
    clear |-> !resp_ready);

  assert_clear_init_R5: assert property (@(posedge clk) disable iff (!rst_n)
    clear |=> (sig_flat == {K{SIG_SEED}}) && !done && !pass && !proto_err);

  assert_err_set_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!clear && resp_valid && resp_ready && ($countones(resp_data) != 1)) |=> proto_err);

  assert_err_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (proto_err && !clear) |=> proto_err);

  assert_done_after_finish_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (finish && !clear) |=> done);

  assert_err_blocks_pass_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (finish && !clear && proto_err) |=> !pass);

  assert_pass_implies_done_R7: assert property (@(posedge clk) disable iff (!rst_n)
    pass |-> done);
endmodule

bind onehot_crc_compactor onehot_crc_compactor_chk #(.K(K)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .clear      (clear),
  .resp_valid (resp_valid),
  .resp_ready (resp_ready),
  .resp_data  (resp_data),
  .finish     (finish),
  .done       (done),
  .pass       (pass),
  .proto_err  (proto_err),
  .sig_flat   (sig_flat)
);

// File: tb/onehot_crc_compactor_bench.sv
`timescale 1ns/1ps
module onehot_crc_compactor_bench;
  localparam int K  = 10;
  localparam int SW = 16;

  logic clk = 0, rst_n = 0, clear = 0, resp_valid = 0, finish = 0;
  logic [K-1:0] resp_data = '0;
  logic [K*SW-1:0] golden_sig = '0;
  logic resp_ready, done, pass, proto_err;

  int n_chk = 0, n_bad = 0;
  bit finished = 0;
  logic [SW-1:0] model [K];
  bit model_err;

  always #2 clk = ~clk;

  onehot_crc_compactor #(.K(K)) u_onehot_crc_compactor (
    .clk(clk), .rst_n(rst_n), .clear(clear), .resp_valid(resp_valid),
    .resp_ready(resp_ready), .resp_data(resp_data), .golden_sig(golden_sig),
    .finish(finish), .done(done), .pass(pass), .proto_err(proto_err));

  function automatic logic [SW-1:0] lane_step(input logic [SW-1:0] s, input logic b);
    logic fb = s[SW-1] ^ b;
    return {s[SW-2:0], 1'b0} ^ (fb ? 16'h1021 : 16'h0000);
  endfunction

  function automatic logic [K*SW-1:0] model_golden();
    logic [K*SW-1:0] g;
    for (int i = 0; i < K; i++) g[i*SW +: SW] = model[i];
    return g;
  endfunction

  function automatic logic [K-1:0] rand_onehot();
    return K'(1) << ($urandom % K);
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic model_reset();
    for (int i = 0; i < K; i++) model[i] = 16'hFFFF;
    model_err = 0;
  endtask

  task automatic do_clear();
    clear = 1;
    @(negedge clk);
    clear = 0;
    model_reset();
  endtask

  // drive a response for one cycle; no clear, so it is accepted
  task automatic send(input logic [K-1:0] v);
    resp_valid = 1; resp_data = v;
    @(negedge clk);
    resp_valid = 0; resp_data = '0;
    for (int i = 0; i < K; i++) model[i] = lane_step(model[i], v[i]);
    if ($countones(v) != 1) model_err = 1;
  endtask

  task automatic do_finish(input string req, input logic [K*SW-1:0] g, input bit exp_pass);
    golden_sig = g; finish = 1;
    @(negedge clk);
    finish = 0;
    check(req, done, 1);
    check(req, pass, exp_pass);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual hung expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic [K*SW-1:0] g;
    void'($urandom(32'h5EED_1234));
    model_reset();
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    check("R1 done", done, 0);
    check("R1 pass", pass, 0);
    check("R1 err", proto_err, 0);
    check("R1 ready", resp_ready, 1);
    do_finish("R1 init sigs", {K{16'hFFFF}}, 1);

    // R2/R3: random one-hot stream with idle gaps
    do_clear();
    check("R5 done cleared", done, 0);
    for (int n = 0; n < 40; n++) begin
      send(rand_onehot());
      repeat ($urandom % 3) @(negedge clk);
    end
    do_finish("R2 crc stream", model_golden(), 1);
    repeat (5) @(negedge clk);
    do_finish("R3 hold across finish/idle", model_golden(), 1);

    // R8: single lane mismatch
    g = model_golden(); g[3*SW + 7] = ~g[3*SW + 7];
    do_finish("R8 lane3 mismatch", g, 0);
    g = model_golden(); g[(K-1)*SW] = ~g[(K-1)*SW];
    do_finish("R8 last lane mismatch", g, 0);

    // R4: response offered during clear is not absorbed
    clear = 1; resp_valid = 1; resp_data = K'(1);
    #1 check("R4 ready low in clear", resp_ready, 0);
    @(negedge clk);
    clear = 0; resp_valid = 0; resp_data = '0;
    model_reset();
    do_finish("R4 clear-cycle offer ignored", {K{16'hFFFF}}, 1);

    // R6/R7: zero vector sets sticky error
    do_clear();
    send(rand_onehot());
    send('0);
    check("R6 zero vec err", proto_err, 1);
    send(rand_onehot());
    repeat (4) @(negedge clk);
    check("R6 sticky", proto_err, 1);
    do_finish("R7 err forces fail", model_golden(), 0);
    do_clear();
    check("R5 err cleared", proto_err, 0);
    check("R5 pass cleared", pass, 0);
    send(K'(3));
    check("R6 two-hot err", proto_err, 1);
    do_finish("R7 two-hot fail", model_golden(), 0);

    // random rounds mixing corruption and bad vectors
    for (int r = 0; r < 30; r++) begin
      bit flip;
      do_clear();
      for (int n = 0; n < 5 + ($urandom % 60); n++) begin
        logic [K-1:0] v = rand_onehot();
        if (($urandom % 50) == 0) v = ($urandom % 2) ? '0 : v | rand_onehot() | K'(1) << ((($urandom % (K-1)) + 1 + $clog2(v+1)) % K);
        send(v);
        repeat ($urandom % 2) @(negedge clk);
      end
      check("R6 random err flag", proto_err, model_err);
      g = model_golden();
      flip = ($urandom % 3) == 0;
      if (flip) g[($urandom % K)*SW + ($urandom % SW)] ^= 1'b1;
      do_finish("R7/R8 random round", g, !flip && !model_err);
    end

    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule